// File: doc/BRIEF.md
# Serial Flash Hold Controller

This block sits at the front of a serial flash slave interface. It decides when serial traffic is paused by the active-low hold input, and it tells the rest of the interface what to do. The command decoder and the data path do not watch the raw pins. They use the gates this block drives. One gate enables the shift logic. The other enables the serial output driver, so a low value means the output floats.

The chip-select, serial-clock and hold pins are sampled by the system clock through synchronizer chains. Every decision is taken on the synchronized levels. A pause starts only inside an open transaction, and only while the serial clock is low. If the serial clock is high, entry is held back until it goes low. Release from a pause follows the same rule. Chip-select rising during a pause produces a one-cycle reset pulse for the interface. A new transaction opens only when chip-select falls while hold is high. Internal status-write, program and erase work is not driven by this block, so a pause has no effect on it.

Top module: `spi_hold_ctrl`

## Requirements
- R1: During reset and right after it, hold_active, so_oe, shift_en and if_rst are all 0.
- R2: A chip-select fall (cs_n to 0) while hold_n is 1 opens a transaction, and shift_en and so_oe become 1.
- R3: In an open transaction, hold_n = 0 with sclk = 0 sets hold_active to 1, and both shift_en and so_oe drop to 0.
- R4: While sclk is 1, hold_n going low does not start a pause; the pause starts once sclk is seen low.
- R5: A pause ends when hold_n is 1 and sclk is 0; while sclk stays 1, hold_active stays 1.
- R6: hold_n low while cs_n is 1 does not set hold_active.
- R7: cs_n rising during a pause gives exactly one cycle of if_rst = 1, clears hold_active and turns both gates off.
- R8: A cs_n fall while hold_n is 0 does not open a transaction. The gates stay 0 even after hold_n later goes high, until cs_n is cycled with hold_n high.
- R9: cs_n rising when no pause is active gives no if_rst pulse and turns the gates off.
- R10: Every output responds on the third rising clk edge after the pin change (two synchronizer stages plus one state register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select pin, active low |
| sclk | input | 1 | Serial clock pin |
| hold_n | input | 1 | Hold pin, active low |
| hold_active | output | 1 | Pause in effect |
| so_oe | output | 1 | Serial output driver enable |
| shift_en | output | 1 | Shift and bit-counter clock enable |
| if_rst | output | 1 | One-cycle reset pulse for the interface logic |

## Verification
Every output of this block is due on the third rising edge after a pin change. The bench changes pins at a falling edge, waits three rising edges and samples at the next falling edge, so each result is read in the first cycle it must hold. The reset pulse is checked in that cycle and again one cycle later, which confirms its width. Deferred entry and exit are checked by holding sclk high for five cycles, checking that nothing has changed, and then checking again three edges after sclk falls.

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic hold_n,
  output logic hold_active,
  output logic so_oe,
  output logic shift_en,
  output logic if_rst
);
  localparam int LAST = SYNC_STAGES - 1;

  typedef enum logic [1:0] {S_IDLE, S_OPEN, S_BLOCKED} sess_t;

  logic [SYNC_STAGES-1:0] cs_sy, sclk_sy, hold_sy;
  logic cs_s, sclk_s, hold_s;
  sess_t sess, sess_nxt;
  logic hold_nxt, rst_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sy   <= '1;
      sclk_sy <= '0;
      hold_sy <= '1;
    end else begin
      cs_sy   <= {cs_sy[LAST-1:0], cs_n};
      sclk_sy <= {sclk_sy[LAST-1:0], sclk};
      hold_sy <= {hold_sy[LAST-1:0], hold_n};
    end
  end

  assign cs_s   = cs_sy[LAST];
  assign sclk_s = sclk_sy[LAST];
  assign hold_s = hold_sy[LAST];

  always_comb begin
    sess_nxt = sess;
    case (sess)
      S_IDLE:    if (!cs_s) sess_nxt = hold_s ? S_OPEN : S_BLOCKED;
      S_OPEN:    if (cs_s) sess_nxt = S_IDLE;
      S_BLOCKED: if (cs_s) sess_nxt = S_IDLE;
      default:   sess_nxt = S_IDLE;
    endcase
  end

  always_comb begin
    hold_nxt = 1'b0;
    if (sess == S_OPEN && !cs_s)
      hold_nxt = hold_active ? !(hold_s && !sclk_s) : (!hold_s && !sclk_s);
  end

  assign rst_nxt = (sess == S_OPEN) && cs_s && hold_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sess        <= S_IDLE;
      hold_active <= 1'b0;
      if_rst      <= 1'b0;
    end else begin
      sess        <= sess_nxt;
      hold_active <= hold_nxt;
      if_rst      <= rst_nxt;
    end
  end

  assign shift_en = (sess == S_OPEN) && !hold_active;
  assign so_oe    = shift_en;

  p_entry_low_sclk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_active) |-> !$past(sclk_s) && !$past(hold_s));

  p_exit_low_sclk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_active) && !$past(cs_s) |-> $past(hold_s) && !$past(sclk_s));

  p_no_hold_when_deselected_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !hold_active);

  p_rst_single_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    if_rst |=> !if_rst);

  p_rst_only_from_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(if_rst) |-> $past(hold_active) && $past(cs_s));

  p_gate_opens_with_hold_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_en) |-> $past(hold_s) && !$past(cs_s));

  p_gates_off_in_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_active) |-> !so_oe && !shift_en);
endmodule

// File: tb/tb_spi_hold_ctrl.sv
module tb_spi_hold_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, hold_n = 1'b1;
  logic hold_active, so_oe, shift_en, if_rst;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spi_hold_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .hold_n(hold_n),
    .hold_active(hold_active), .so_oe(so_oe), .shift_en(shift_en), .if_rst(if_rst)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic s, input logic h);
    @(negedge clk);
    cs_n = c; sclk = s; hold_n = h;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_idle();
    drive(1'b1, 1'b0, 1'b1);
    settle(4);
  endtask

  task automatic t_reset();
    check("R1", hold_active, 1'b0, "hold_active in reset");
    check("R1", so_oe, 1'b0, "so_oe in reset");
    rst_n = 1'b1;
    settle(2);
    check("R1", shift_en, 1'b0, "shift_en after reset");
    check("R1", if_rst, 1'b0, "if_rst after reset");
  endtask

  task automatic t_open();
    drive(1'b0, 1'b0, 1'b1);
    settle(2);
    check("R10", shift_en, 1'b0, "shift_en before third edge");
    settle(0);
    @(posedge clk); @(negedge clk);
    check("R2", shift_en, 1'b1, "shift_en after open");
    check("R2", so_oe, 1'b1, "so_oe after open");
    go_idle();
  endtask

  task automatic t_hold_basic();
    drive(1'b0, 1'b0, 1'b1); settle(4);
    drive(1'b0, 1'b0, 1'b0); settle(3);
    check("R3", hold_active, 1'b1, "hold_active");
    check("R3", shift_en, 1'b0, "shift_en in hold");
    check("R3", so_oe, 1'b0, "so_oe in hold");
    drive(1'b0, 1'b0, 1'b1); settle(3);
    check("R5", hold_active, 1'b0, "hold released");
    check("R5", shift_en, 1'b1, "shift_en after release");
    go_idle();
  endtask

  task automatic t_deferred_entry();
    drive(1'b0, 1'b1, 1'b1); settle(4);
    drive(1'b0, 1'b1, 1'b0); settle(5);
    check("R4", hold_active, 1'b0, "no entry while sclk high");
    check("R4", shift_en, 1'b1, "shift_en while entry deferred");
    drive(1'b0, 1'b0, 1'b0); settle(3);
    check("R4", hold_active, 1'b1, "entry once sclk low");
    go_idle();
  endtask

  task automatic t_deferred_exit();
    drive(1'b0, 1'b0, 1'b1); settle(4);
    drive(1'b0, 1'b0, 1'b0); settle(4);
    drive(1'b0, 1'b1, 1'b0); settle(3);
    drive(1'b0, 1'b1, 1'b1); settle(5);
    check("R5", hold_active, 1'b1, "no exit while sclk high");
    drive(1'b0, 1'b0, 1'b1); settle(3);
    check("R5", hold_active, 1'b0, "exit once sclk low");
    go_idle();
  endtask

  task automatic t_idle_ignore();
    drive(1'b1, 1'b0, 1'b0); settle(5);
    check("R6", hold_active, 1'b0, "hold_active while deselected");
    check("R6", so_oe, 1'b0, "so_oe while deselected");
    go_idle();
  endtask

  task automatic t_cs_rise_in_hold();
    drive(1'b0, 1'b0, 1'b1); settle(4);
    drive(1'b0, 1'b0, 1'b0); settle(4);
    drive(1'b1, 1'b0, 1'b0); settle(3);
    check("R7", if_rst, 1'b1, "reset pulse");
    check("R7", hold_active, 1'b0, "hold cleared");
    check("R7", shift_en, 1'b0, "shift_en after reset");
    settle(1);
    check("R7", if_rst, 1'b0, "reset pulse width");
    go_idle();
  endtask

  task automatic t_blocked();
    drive(1'b1, 1'b0, 1'b0); settle(4);
    drive(1'b0, 1'b0, 1'b0); settle(4);
    check("R8", shift_en, 1'b0, "no open with hold low");
    drive(1'b0, 1'b0, 1'b1); settle(5);
    check("R8", shift_en, 1'b0, "still blocked after hold high");
    check("R8", so_oe, 1'b0, "so_oe blocked");
    check("R8", hold_active, 1'b0, "no hold while blocked");
    go_idle();
    drive(1'b0, 1'b0, 1'b1); settle(3);
    check("R8", shift_en, 1'b1, "opens after cs cycled");
    go_idle();
  endtask

  task automatic t_cs_rise_plain();
    drive(1'b0, 1'b0, 1'b1); settle(4);
    drive(1'b1, 1'b0, 1'b1); settle(3);
    check("R9", if_rst, 1'b0, "no pulse without hold");
    check("R9", shift_en, 1'b0, "gates off after deselect");
    settle(1);
    check("R9", if_rst, 1'b0, "no late pulse");
  endtask

  initial begin
    #200_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_open();
    t_hold_basic();
    t_deferred_entry();
    t_deferred_exit();
    t_idle_ignore();
    t_cs_rise_in_hold();
    t_blocked();
    t_cs_rise_plain();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule